// File: doc/BRIEF.md
# Ternary Search Array with Rippled Row Match

This block is a small ternary content-addressable store of four words, each five bits wide. Every bit position holds a value bit and a wildcard bit. A wildcard position accepts either search value; a non-wildcard position accepts only the value it holds. A search word is compared with all stored words at once. The block returns three results: a vector marking every matching word, a hit flag, and the index of the lowest-numbered matching word. Software should place the more specific entries, for example longer prefixes, in the lower rows so that they take precedence.

The match for each row is built as a serial chain. The first link is seeded with 1, and each bit position ANDs its own local verdict onto the value that arrives from the previous position. A per-position 2-to-1 select chooses between the equality result and a constant 1, according to the wildcard bit. Writes are synchronous. They go to the row picked by a 2-to-4 address decoder, and that decoder is gated by a write enable. The search word is registered on the input side, and the results are registered on the output side.

Top module: `tcam_chain_top`

## Requirements
- R1: While rst_n is low, match_vec_o, hit_o and hit_idx_o are 0 at each clock edge, and all value and wildcard bits are cleared to 0. After reset, an all-zero search therefore matches every row: match_vec_o = 4'b1111, hit_o = 1 and hit_idx_o = 0.
- R2: When wr_en_i is 1 at a rising edge, row wr_addr_i takes wr_data_i as its value bits and wr_mask_i as its wildcard bits. No other row changes.
- R3: When wr_en_i is 0, no row changes, whatever values wr_addr_i, wr_data_i and wr_mask_i carry.
- R4: A bit position whose wildcard bit is 1 accepts both search values, 0 and 1.
- R5: A bit position whose wildcard bit is 0 accepts only a search bit equal to its stored value bit.
- R6: A row matches only when every one of its bit positions accepts. A row whose wildcard bits are all 1 matches every search word.
- R7: Bit r of match_vec_o is 1 exactly when row r matches. When at least one row matches, hit_o is 1 and hit_idx_o holds the smallest r with a match.
- R8: When no row matches, match_vec_o is 0, hit_o is 0 and hit_idx_o is 0.
- R9: srch_i is captured at a rising edge, and the results for it appear on the outputs after the next rising edge. Between those two edges the outputs keep their previous values.
- R10: When a write and a search word are presented in the same cycle, the result for that search reflects the word just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write enable; gates the row decoder |
| wr_addr_i | input | 2 | Row to write |
| wr_data_i | input | 5 | Value bits to store |
| wr_mask_i | input | 5 | Wildcard bits to store (1 = any value) |
| srch_i | input | 5 | Search word |
| match_vec_o | output | 4 | Per-row match flags, registered |
| hit_o | output | 1 | At least one row matched |
| hit_idx_o | output | 2 | Lowest matching row index |

## Verification
A write and a search can land on the same clock edge. The write updates a row while the search word is captured, and the stored word is compared only in the following cycle. The bench provokes this by driving a write and a search word in the same cycle, often with the search set equal to the word being written. It judges the outcome against a behavioural model that applies the write before it evaluates the search. The bench also repeats the case with the write enable low and stray address, value and wildcard bits, and checks that the search then sees the old contents.

// File: rtl/tcam_pkg.sv
// Package: shared sizes and gate-style helper functions for the ternary array.
// Assumes: helpers are pure combinational single-bit functions.
package tcam_pkg;
    parameter int unsigned TCAM_ROWS = 4;
    parameter int unsigned TCAM_COLS = 5;

    // Equality of two bits (inverted exclusive-or).
    function automatic logic f_same(input logic a, input logic b);
        return ~(a ^ b);
    endfunction

    // Two-input select: returns b when sel is 1, else a.
    function automatic logic f_sel(input logic sel, input logic a, input logic b);
        return sel ? b : a;
    endfunction

    // Two-input conjunction used as one link of a match chain.
    function automatic logic f_link(input logic a, input logic b);
        return a & b;
    endfunction
endpackage

// File: rtl/tcam_row_dec.sv
// Module: write row decoder with enable. Produces a one-hot row select
// when en_i is high and all zeros otherwise.
// Assumes: addr_i is always within ROWS.
module tcam_row_dec #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned AW   = 2
) (
    input  logic            en_i,
    input  logic [AW-1:0]   addr_i,
    output logic [ROWS-1:0] sel_o
);
    // Decode the address into a gated one-hot select.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            sel_o[r] = en_i && (addr_i == AW'(r));
        end
    end
endmodule

// File: rtl/tcam_cell.sv
// Module: one ternary bit position. Compares the stored bit with the
// search bit, substitutes a constant 1 when the wildcard bit is set, and
// ANDs the verdict onto the incoming chain value.
// Assumes: purely combinational; storage lives in the enclosing row.
module tcam_cell
    import tcam_pkg::*;
(
    input  logic val_i,
    input  logic wild_i,
    input  logic srch_i,
    input  logic chain_i,
    output logic chain_o
);
    logic eq;
    logic local_ok;

    // Local verdict: equality, overridden to 1 by the wildcard select.
    always_comb begin
        eq       = f_same(val_i, srch_i);
        local_ok = f_sel(wild_i, eq, 1'b1);
        chain_o  = f_link(chain_i, local_ok);
    end
endmodule

// File: rtl/tcam_row.sv
// Module: one stored word. Holds the value and wildcard bits, and forms
// the row match as a ripple chain of cells seeded with 1.
// Assumes: we_i comes from the gated decoder; srch_i is already registered.
module tcam_row #(
    parameter int unsigned COLS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [COLS-1:0] data_i,
    input  logic [COLS-1:0] mask_i,
    input  logic [COLS-1:0] srch_i,
    output logic            match_o
);
    logic [COLS-1:0] data_q;
    logic [COLS-1:0] mask_q;
    logic [COLS:0]   chain;

    // Store value and wildcard bits on a selected write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else if (we_i) begin
            data_q <= data_i;
            mask_q <= mask_i;
        end
    end

    // Seed the chain like a precharged matchline.
    assign chain[0] = 1'b1;

    genvar c;
    generate
        for (c = 0; c < COLS; c++) begin : g_cell
            tcam_cell u_cell (
                .val_i   (data_q[c]),
                .wild_i  (mask_q[c]),
                .srch_i  (srch_i[c]),
                .chain_i (chain[c]),
                .chain_o (chain[c+1])
            );
        end
    endgenerate

    assign match_o = chain[COLS];

    // R3: contents hold when not selected for writing.
    p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(data_q) && $stable(mask_q)));

    // R6: a row with every wildcard set matches any search word.
    p_allwild_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> match_o);

    // R5: with no wildcards, the row matches exactly on equality.
    p_exact_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (match_o == (data_q == srch_i)));
endmodule

// File: rtl/tcam_prio_enc.sv
// Module: priority encoder. Reports whether any row matched and the
// index of the lowest-numbered matching row (0 when none match).
// Assumes: IW is wide enough to index ROWS.
module tcam_prio_enc #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned IW   = 2
) (
    input  logic [ROWS-1:0] vec_i,
    output logic            hit_o,
    output logic [IW-1:0]   idx_o
);
    // Scan from the top down so that the lowest match wins.
    always_comb begin
        idx_o = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (vec_i[r]) idx_o = IW'(r);
        end
        hit_o = |vec_i;
    end
endmodule

// File: rtl/tcam_chain_top.sv
// Module: ternary search array top. Registers the search word, compares
// it with every row through the ripple chains, and registers the match
// vector, hit flag and lowest matching index.
// Assumes: synchronous active-low reset; one write port; search every cycle.
module tcam_chain_top
    import tcam_pkg::*;
#(
    parameter int unsigned ROWS = TCAM_ROWS,
    parameter int unsigned COLS = TCAM_COLS,
    localparam int unsigned IW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [IW-1:0]   wr_addr_i,
    input  logic [COLS-1:0] wr_data_i,
    input  logic [COLS-1:0] wr_mask_i,
    input  logic [COLS-1:0] srch_i,
    output logic [ROWS-1:0] match_vec_o,
    output logic            hit_o,
    output logic [IW-1:0]   hit_idx_o
);
    logic [COLS-1:0] srch_q;
    logic [ROWS-1:0] wr_sel;
    logic [ROWS-1:0] row_match;
    logic            enc_hit;
    logic [IW-1:0]   enc_idx;

    // Capture the search word.
    always_ff @(posedge clk) begin
        if (!rst_n) srch_q <= '0;
        else        srch_q <= srch_i;
    end

    tcam_row_dec #(.ROWS(ROWS), .AW(IW)) u_dec (
        .en_i   (wr_en_i),
        .addr_i (wr_addr_i),
        .sel_o  (wr_sel)
    );

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            tcam_row #(.COLS(COLS)) u_row (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_i    (wr_sel[r]),
                .data_i  (wr_data_i),
                .mask_i  (wr_mask_i),
                .srch_i  (srch_q),
                .match_o (row_match[r])
            );
        end
    endgenerate

    tcam_prio_enc #(.ROWS(ROWS), .IW(IW)) u_enc (
        .vec_i (row_match),
        .hit_o (enc_hit),
        .idx_o (enc_idx)
    );

    // Register the search results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec_o <= '0;
            hit_o       <= 1'b0;
            hit_idx_o   <= '0;
        end else begin
            match_vec_o <= row_match;
            hit_o       <= enc_hit;
            hit_idx_o   <= enc_idx;
        end
    end

    // R2: at most one row is selected for a write.
    p_dec_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R3: no row is selected while the write enable is low.
    p_dec_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |-> (wr_sel == '0));

    // R8: without a hit, the index and the vector are zero.
    p_nohit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> ((hit_idx_o == '0) && (match_vec_o == '0)));

    // R7: the reported index is a matching row, and no lower row matches.
    p_lowest_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (match_vec_o[hit_idx_o] &&
                   ((match_vec_o & ((ROWS'(1) << hit_idx_o) - ROWS'(1))) == '0)));
endmodule

// File: tb/tcam_chain_top_bench.sv
// Bench: walks a vector table of writes and searches against a behavioural
// ternary model, then runs directed checks for reset and latency.
module tcam_chain_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic [4:0] wr_mask = '0;
    logic [4:0] srch = '0;
    logic [3:0] match_vec;
    logic       hit;
    logic [1:0] hit_idx;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    logic [4:0] m_data [4];
    logic [4:0] m_mask [4];
    logic [3:0] e_vec;
    logic       e_hit;
    logic [1:0] e_idx;

    always #5 clk = ~clk;

    tcam_chain_top u_tcam_chain_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .wr_mask_i   (wr_mask),
        .srch_i      (srch),
        .match_vec_o (match_vec),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx)
    );

    // Entry: {we, addr[1:0], data[4:0], mask[4:0], search[4:0]}
    localparam int NV = 14;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 2'd0, 5'b10110, 5'b00000, 5'b10110},
        {1'b1, 2'd1, 5'b10100, 5'b00011, 5'b10111},
        {1'b1, 2'd2, 5'b00000, 5'b11111, 5'b01010},
        {1'b1, 2'd3, 5'b11111, 5'b00000, 5'b11111},
        {1'b0, 2'd0, 5'b11111, 5'b11111, 5'b10110},
        {1'b0, 2'd3, 5'b00000, 5'b11111, 5'b11111},
        {1'b1, 2'd2, 5'b00000, 5'b00000, 5'b00001},
        {1'b0, 2'd0, 5'b00000, 5'b00000, 5'b10101},
        {1'b0, 2'd1, 5'b01010, 5'b10101, 5'b10110},
        {1'b1, 2'd0, 5'b00000, 5'b11111, 5'b01101},
        {1'b0, 2'd2, 5'b11111, 5'b00000, 5'b11111},
        {1'b1, 2'd1, 5'b00001, 5'b11110, 5'b00000},
        {1'b1, 2'd3, 5'b01100, 5'b10001, 5'b11101},
        {1'b0, 2'd3, 5'b00000, 5'b00000, 5'b00000}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 4; r++) begin
            m_data[r] = '0;
            m_mask[r] = '0;
        end
    endtask

    task automatic model_eval(input logic [4:0] s);
        e_vec = '0;
        for (int r = 0; r < 4; r++)
            e_vec[r] = &(m_mask[r] | ~(m_data[r] ^ s));
        e_hit = |e_vec;
        e_idx = '0;
        for (int r = 3; r >= 0; r--)
            if (e_vec[r]) e_idx = 2'(r);
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " match vector"}, int'(match_vec), int'(e_vec));
        chk({tag, " hit"}, int'(hit), int'(e_hit));
        chk({tag, " index"}, int'(hit_idx), int'(e_idx));
    endtask

    // Drive one vector, apply it to the model, and check two edges later.
    task automatic step(input logic [17:0] v);
        @(negedge clk);
        wr_en   = v[17];
        wr_addr = v[16:15];
        wr_data = v[14:10];
        wr_mask = v[9:5];
        srch    = v[4:0];
        if (v[17]) begin
            m_data[v[16:15]] = v[14:10];
            m_mask[v[16:15]] = v[9:5];
        end
        model_eval(v[4:0]);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check_outputs("R2 R3 R4 R5 R6 R7 R8 R10 table");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: outputs are zero while reset is held.
        repeat (3) @(negedge clk);
        chk("R1 reset vector", int'(match_vec), 0);
        chk("R1 reset hit", int'(hit), 0);
        chk("R1 reset index", int'(hit_idx), 0);
        rst_n = 1'b1;
        // R1: the cleared array matches an all-zero search on every row.
        repeat (2) @(negedge clk);
        chk("R1 cleared array vector", int'(match_vec), 15);
        chk("R1 cleared array hit", int'(hit), 1);
        chk("R1 cleared array index", int'(hit_idx), 0);

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R9: a new search word shows only after the second edge.
        model_eval(5'b11111);
        begin
            logic [3:0] old_vec;
            old_vec = e_vec;
            step({1'b1, 2'd3, 5'b00000, 5'b00000, 5'b11011});
            @(negedge clk);
            srch = 5'b00000;
            @(negedge clk);
            chk("R9 held after one edge", int'(match_vec), int'(e_vec));
            model_eval(5'b00000);
            @(negedge clk);
            chk("R9 updated after two edges", int'(match_vec), int'(e_vec));
            if (old_vec == e_vec) chk("R9 distinct results", 0, 1);
        end

        // R1: a mid-run reset clears stored words and outputs.
        @(negedge clk);
        rst_n = 1'b0;
        srch  = 5'b10101;
        @(negedge clk);
        chk("R1 mid-run reset hit", int'(hit), 0);
        rst_n = 1'b1;
        model_reset();
        model_eval(5'b10101);
        repeat (2) @(negedge clk);
        check_outputs("R1 R8 after mid-run reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule